// File: doc/BRIEF.md
# Write Status Readback Generator

This block sits between the flash array's read path and the external data bus. While an internal program or erase runs, it replaces the array byte with a status byte. The top bit reports completion: during a program it reads as the inverse of bit 7 of the byte being written, and during an erase it reads as 0. The next bit flips on every read while the operation lasts. All lower bits read as 0.

When the busy flag drops, a settling window of `SETTLE_CYCLES` clock cycles follows. In that window only the top bit carries real array data, and every other bit reads as 0. After the window, reads pass the array byte through unchanged. Each read strobe captures one byte into the output register. The output holds between strobes.

Top module: `srg_status_readback`

## Requirements
- R1: While rst_ni is low, rd_data_o is 0.
- R2: When idle (no operation running and no settling window open), a read strobe sampled at a clock edge loads that cycle's array_data_i into rd_data_o at that edge.
- R3: rd_data_o changes only at an edge where rd_i is high.
- R4: From the first clock edge after busy_i is seen high, a read during a program (op_erase_i low at start) returns bit 7 as the complement of prog_msb_i.
- R5: A read during an erase (op_erase_i high at start) returns bit 7 as 0.
- R6: While busy, bit 6 alternates on successive reads, and the first read of each new operation returns 0.
- R7: While busy, bits 5 to 0 read as 0.
- R8: For the SETTLE_CYCLES edges after busy_i is seen low, a read returns array bit 7 in bit 7 and 0 in bits 6 to 0, so bit 6 stops toggling.
- R9: After the settling window, reads return the full array byte again.
- R10: op_erase_i and prog_msb_i are latched when the operation starts; changes while busy have no effect on the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| busy_i | input | 1 | Internal program or erase in progress |
| op_erase_i | input | 1 | Operation type: 1 erase, 0 program |
| prog_msb_i | input | 1 | Bit 7 of the byte being programmed |
| rd_i | input | 1 | Read strobe |
| array_data_i | input | DW | True byte from the array |
| rd_data_o | output | DW | Byte returned to the bus |

## Verification
The assertions check on every cycle that the output holds when there is no strobe, that the low bits stay zero while busy and while settling, that an erase reports 0, that consecutive busy reads flip bit 6, and that idle reads pass the array byte through. Some behaviours only the bench scenarios can show. These are the toggle restarting at 0 on a new operation, latching of the operation type and program bit against later input changes, the exact last edge of the settling window, and the program completion value.

// File: rtl/srg_pkg.sv
package srg_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_BUSY   = 2'd1,
    PH_SETTLE = 2'd2
  } phase_e;
endpackage

// File: rtl/srg_phase_ctrl.sv
module srg_phase_ctrl
  import srg_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 33
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   busy_i,
  input  logic   op_erase_i,
  input  logic   prog_msb_i,
  output phase_e phase_o,
  output logic   start_o,
  output logic   erase_o,
  output logic   prog_msb_o
);
  localparam int unsigned CNT_W = $clog2(SETTLE_CYCLES + 1) > 0 ? $clog2(SETTLE_CYCLES + 1) : 1;

  logic             busy_q;
  logic             erase_q;
  logic             msb_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done;

  assign start_o = busy_i & ~busy_q;
  assign done    = ~busy_i & busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      erase_q <= 1'b0;
      msb_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      busy_q <= busy_i;
      if (start_o) begin
        erase_q <= op_erase_i;
        msb_q   <= prog_msb_i;
        cnt_q   <= '0;
      end else if (done) begin
        cnt_q <= CNT_W'(SETTLE_CYCLES);
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  always_comb begin
    if (busy_q)            phase_o = PH_BUSY;
    else if (cnt_q != '0)  phase_o = PH_SETTLE;
    else                   phase_o = PH_IDLE;
  end

  assign erase_o    = erase_q;
  assign prog_msb_o = msb_q;
endmodule

// File: rtl/srg_toggle.sv
module srg_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic adv_i,
  output logic tgl_o
);
  logic tgl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      tgl_q <= 1'b0;
    else if (start_i) tgl_q <= 1'b0;
    else if (adv_i)   tgl_q <= ~tgl_q;
  end

  assign tgl_o = tgl_q;
endmodule

// File: rtl/srg_byte_mux.sv
module srg_byte_mux
  import srg_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  phase_e        phase_i,
  input  logic          erase_i,
  input  logic          prog_msb_i,
  input  logic          tgl_i,
  input  logic [DW-1:0] array_i,
  output logic [DW-1:0] byte_o
);
  always_comb begin
    byte_o = '0;
    unique case (phase_i)
      PH_BUSY: begin
        byte_o[DW-1] = erase_i ? 1'b0 : ~prog_msb_i;
        byte_o[DW-2] = tgl_i;
      end
      PH_SETTLE: byte_o[DW-1] = array_i[DW-1];
      PH_IDLE:   byte_o = array_i;
      default:   byte_o = '0;
    endcase
  end
endmodule

// File: rtl/srg_status_readback.sv
module srg_status_readback
  import srg_pkg::*;
#(
  parameter int unsigned DW            = 8,
  parameter int unsigned SETTLE_CYCLES = 33
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          busy_i,
  input  logic          op_erase_i,
  input  logic          prog_msb_i,
  input  logic          rd_i,
  input  logic [DW-1:0] array_data_i,
  output logic [DW-1:0] rd_data_o
);
  phase_e        phase;
  logic          start;
  logic          erase_q;
  logic          msb_q;
  logic          tgl;
  logic [DW-1:0] rd_byte;
  logic [DW-1:0] rd_data_q;

  srg_phase_ctrl #(.SETTLE_CYCLES(SETTLE_CYCLES)) i_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .busy_i     (busy_i),
    .op_erase_i (op_erase_i),
    .prog_msb_i (prog_msb_i),
    .phase_o    (phase),
    .start_o    (start),
    .erase_o    (erase_q),
    .prog_msb_o (msb_q)
  );

  srg_toggle i_toggle (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .adv_i   (rd_i && phase == PH_BUSY),
    .tgl_o   (tgl)
  );

  srg_byte_mux #(.DW(DW)) i_mux (
    .phase_i    (phase),
    .erase_i    (erase_q),
    .prog_msb_i (msb_q),
    .tgl_i      (tgl),
    .array_i    (array_data_i),
    .byte_o     (rd_byte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rd_data_q <= '0;
    else if (rd_i) rd_data_q <= rd_byte;
  end

  assign rd_data_o = rd_data_q;
endmodule

// File: rtl/srg_status_readback_chk.sv
module srg_status_readback_chk
  import srg_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rd_i,
  input logic [DW-1:0] array_data_i,
  input logic [DW-1:0] rd_data_o,
  input phase_e        phase_i,
  input logic          erase_i
);
  a_r3_hold_without_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rd_data_o));

  a_r7_busy_low_bits_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && phase_i == PH_BUSY) |=> rd_data_o[DW-3:0] == '0);

  a_r5_erase_reports_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && phase_i == PH_BUSY && erase_i) |=> !rd_data_o[DW-1]);

  a_r6_toggle_flips: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && phase_i == PH_BUSY) ##1 (rd_i && phase_i == PH_BUSY)
      |=> rd_data_o[DW-2] != $past(rd_data_o[DW-2]));

  a_r8_settle_low_bits_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && phase_i == PH_SETTLE) |=> rd_data_o[DW-2:0] == '0);

  a_r2_idle_passthrough: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && phase_i == PH_IDLE) |=> rd_data_o == $past(array_data_i));
endmodule

bind srg_status_readback srg_status_readback_chk #(.DW(DW)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rd_i         (rd_i),
  .array_data_i (array_data_i),
  .rd_data_o    (rd_data_o),
  .phase_i      (phase),
  .erase_i      (erase_q)
);

// File: tb/test_srg_status_readback.sv
module test_srg_status_readback;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned DW         = 8;
  localparam int unsigned SETTLE     = 5;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          busy_i = 1'b0;
  logic          op_erase_i = 1'b0;
  logic          prog_msb_i = 1'b0;
  logic          rd_i = 1'b0;
  logic [DW-1:0] array_data_i = '0;
  logic [DW-1:0] rd_data_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  srg_status_readback #(.DW(DW), .SETTLE_CYCLES(SETTLE)) i_srg_status_readback (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .busy_i       (busy_i),
    .op_erase_i   (op_erase_i),
    .prog_msb_i   (prog_msb_i),
    .rd_i         (rd_i),
    .array_data_i (array_data_i),
    .rd_data_o    (rd_data_o)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [DW-1:0] arr);
    array_data_i = arr;
    rd_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  task automatic start_op(input logic erase, input logic msb);
    op_erase_i = erase;
    prog_msb_i = msb;
    busy_i = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic end_op();
    busy_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic wait_idle();
    repeat (SETTLE + 2) @(negedge clk_i);
  endtask

  task automatic t_reset();
    check("R1 reset", rd_data_o, 8'h00);
  endtask

  task automatic t_idle();
    do_read(8'h5A);
    check("R2 idle read", rd_data_o, 8'h5A);
    do_read(8'hC3);
    check("R2 idle read 2", rd_data_o, 8'hC3);
  endtask

  task automatic t_hold();
    array_data_i = 8'h11;
    repeat (3) @(negedge clk_i);
    check("R3 hold without strobe", rd_data_o, 8'hC3);
  endtask

  task automatic t_program();
    start_op(1'b0, 1'b0);
    do_read(8'hFF);
    check("R4 R6 R7 program read 1", rd_data_o, 8'h80);
    do_read(8'hFF);
    check("R6 program read 2", rd_data_o, 8'hC0);
    do_read(8'hFF);
    check("R6 program read 3", rd_data_o, 8'h80);
    end_op();
    wait_idle();
    start_op(1'b0, 1'b1);
    do_read(8'h7F);
    check("R4 R7 program msb one", rd_data_o, 8'h00);
    end_op();
    wait_idle();
  endtask

  task automatic t_erase();
    start_op(1'b1, 1'b0);
    do_read(8'hFF);
    check("R5 R6 erase read 1 toggle restarts", rd_data_o, 8'h00);
    do_read(8'hFF);
    check("R5 R6 erase read 2", rd_data_o, 8'h40);
    end_op();
    do_read(8'hFF);
    check("R8 first settle read", rd_data_o, 8'h80);
    do_read(8'hFF);
    check("R8 second settle read toggle stopped", rd_data_o, 8'h80);
    do_read(8'h7F);
    check("R8 settle bit7 from array", rd_data_o, 8'h00);
    repeat (SETTLE - 4) @(negedge clk_i);
    do_read(8'hFF);
    check("R8 last settle edge", rd_data_o, 8'h80);
    do_read(8'hFF);
    check("R9 full byte after window", rd_data_o, 8'hFF);
  endtask

  task automatic t_latch();
    start_op(1'b1, 1'b0);
    op_erase_i = 1'b0;
    prog_msb_i = 1'b0;
    do_read(8'hFF);
    check("R10 erase kept after op change", rd_data_o, 8'h00);
    end_op();
    wait_idle();
    start_op(1'b0, 1'b0);
    prog_msb_i = 1'b1;
    do_read(8'hFF);
    check("R10 program bit kept", rd_data_o, 8'h80);
    end_op();
    wait_idle();
    do_read(8'h3C);
    check("R9 idle after latch test", rd_data_o, 8'h3C);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_idle();
    t_hold();
    t_program();
    t_erase();
    t_latch();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule